// File: doc/BRIEF.md
# Decimal Stopwatch Counter

This block is a five-digit decimal stopwatch. An internal prescaler divides the system clock into a one-cycle tick every 10 ms. Each tick adds one hundredth of a second to a packed BCD count. The count covers 000.00 to 999.99 seconds and then wraps. A run control starts and stops the count, and a synchronous reset returns it to zero.

Each decimal digit is its own single-digit incrementer. A digit that wraps from 9 to 0 raises a carry, and that carry is the advance enable of the next digit up. The seconds and hundredths fields therefore come out of one cascaded chain. A display path or a register interface reads the 20-bit value directly.

Top module: `bcd_stopwatch`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the count and the prescaler are cleared. The count reads 000.00 after that edge.
- R2: The value is five 4-bit BCD digits, most significant first. Bits [19:8] hold the whole seconds, and bits [7:0] hold the hundredths of a second.
- R3: While run is high, the count advances by exactly one hundredth once every CLK_HZ/TICK_HZ clock cycles.
- R4: A hundredths digit that steps past 9 returns to 0 and carries into the tenths digit (0.09 becomes 0.10).
- R5: Carries ripple through every digit that holds 9 (0.99 becomes 1.00, 9.99 becomes 10.00, 99.99 becomes 100.00).
- R6: A tick at 999.99 gives 000.00. The carry out of the top digit is dropped.
- R7: While run is low, both the count and the prescaler phase hold. On resume, the partial tick period continues where it stopped.
- R8: A reset in the middle of a tick period restarts the prescaler. The first advance after the reset comes a full period later.
- R9: Every digit stays within 0 to 9 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to count, low to hold |
| value | output | 20 | Packed BCD count, seconds in [19:8], hundredths in [7:0] |

## Verification
The count register changes on the same clock edge that ends a tick period. With a divisor of 1, the value after k run edges is k counts. With a divisor of 4, the change is due on the fourth run edge after reset, and every fourth run edge after that. The bench drives and samples on the falling edge and counts rising edges exactly, so every check falls half a cycle after the edge that should have produced its result. A hold or a reset is checked both at the edge where it takes effect and at the edge where counting resumes.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef logic [3:0] bcd_digit_t;
  localparam bcd_digit_t BCD_ZERO = 4'd0;
  localparam bcd_digit_t BCD_NINE = 4'd9;
endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int DIV = 500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (run) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign tick = run && (phase == LAST);
endmodule

// File: rtl/sw_bcd_stage.sv
module sw_bcd_stage
  import sw_pkg::*;
(
  input  bcd_digit_t d_in,
  input  logic       en,
  output bcd_digit_t d_out,
  output logic       carry
);
  always_comb begin
    d_out = d_in;
    carry = 1'b0;
    if (en) begin
      if (d_in == BCD_NINE) begin
        d_out = BCD_ZERO;
        carry = 1'b1;
      end else begin
        d_out = d_in + 4'd1;
      end
    end
  end
endmodule

// File: rtl/sw_bcd_chain.sv
module sw_bcd_chain
  import sw_pkg::*;
#(
  parameter int NDIG = 5,
  localparam int VW = 4 * NDIG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [VW-1:0] value
);
  logic [VW-1:0] nxt;
  logic [NDIG:0] en_chain;
  logic          top_carry_unused;

  assign en_chain[0] = adv;

  for (genvar i = 0; i < NDIG; i++) begin : g_stage
    sw_bcd_stage u_stage (
      .d_in  (value[4*i +: 4]),
      .en    (en_chain[i]),
      .d_out (nxt[4*i +: 4]),
      .carry (en_chain[i+1])
    );
  end

  assign top_carry_unused = en_chain[NDIG];

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (adv) begin
      value <= nxt;
    end
  end
endmodule

// File: rtl/bcd_stopwatch.sv
module bcd_stopwatch #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int TICK_HZ     = 100,
  parameter int SEC_DIGITS  = 3,
  parameter int FRAC_DIGITS = 2,
  localparam int NDIG = SEC_DIGITS + FRAC_DIGITS,
  localparam int VW   = 4 * NDIG
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [VW-1:0] value
);
  localparam int RAW_DIV = CLK_HZ / TICK_HZ;
  localparam int DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;

  logic tick;

  sw_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  sw_bcd_chain #(.NDIG(NDIG)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .adv   (tick),
    .value (value)
  );
endmodule

// File: rtl/bcd_stopwatch_chk.sv
module bcd_stopwatch_chk #(
  parameter int NDIG = 5,
  localparam int VW = 4 * NDIG
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic [VW-1:0] value
);
  function automatic logic digits_ok(input logic [VW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [VW-1:0] all_nines();
    logic [VW-1:0] r;
    for (int i = 0; i < NDIG; i++) r[4*i +: 4] = 4'd9;
    return r;
  endfunction

  localparam logic [VW-1:0] TOP = all_nines();

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (value == '0));

  a_r9_digits_valid: assert property (@(posedge clk) disable iff (rst)
    digits_ok(value));

  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(value));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (value == TOP) |=> (value == TOP) || (value == '0));

  a_r3_lsd_single_step: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(value) ||
            (value[3:0] == (($past(value[3:0]) == 4'd9) ? 4'd0 : $past(value[3:0]) + 4'd1)));
endmodule

bind bcd_stopwatch bcd_stopwatch_chk #(.NDIG(NDIG)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .run   (run),
  .value (value)
);

// File: tb/tb_bcd_stopwatch.sv
module tb_bcd_stopwatch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int VEC_EDGES [NV] = '{9, 10, 99, 100, 999, 1000, 9999, 10000, 99999, 100000, 100001};

  logic clk = 1'b0;
  logic rst = 1'b1, run = 1'b0;
  logic rst_s = 1'b1, run_s = 1'b0;
  logic [19:0] value, value_s;
  int checks = 0, errors = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_stopwatch #(.CLK_HZ(100)) dut (.clk(clk), .rst(rst), .run(run), .value(value));
  bcd_stopwatch #(.CLK_HZ(400)) dut_slow (.clk(clk), .rst(rst_s), .run(run_s), .value(value_s));

  function automatic logic [19:0] to_bcd(input int n);
    logic [19:0] r = '0;
    int m = n % 100000;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(m % 10);
      m = m / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int done_edges;
    edges(3);
    check("R1 reset state", value, 20'h00000);
    check("R1 reset state slow", value_s, 20'h00000);
    rst = 1'b0;
    edges(5);
    check("R7 stopped after reset", value, 20'h00000);
    run = 1'b1;
    done_edges = 0;
    for (int k = 0; k < NV; k++) begin
      edges(VEC_EDGES[k] - done_edges);
      done_edges = VEC_EDGES[k];
      check("R3/R4/R5/R6 count", value, to_bcd(VEC_EDGES[k]));
      checks++;
      for (int d = 0; d < 5; d++) begin
        if (value[4*d +: 4] > 4'd9) begin
          errors++;
          $display("FAIL R9: digit %0d actual=%h expected<=9", d, value[4*d +: 4]);
          break;
        end
      end
      if (VEC_EDGES[k] == 10000)
        check("R2 seconds field", {8'h0, value[19:8]}, 20'h00100);
      if (VEC_EDGES[k] == 99999)
        check("R2 hundredths field", {12'h0, value[7:0]}, 20'h00099);
    end
    run = 1'b0;
    edges(7);
    check("R7 hold while stopped", value, 20'h00001);
    run = 1'b1;
    edges(4);
    check("R3 resume", value, 20'h00005);
    rst = 1'b1;
    edges(1);
    check("R1 reset while running", value, 20'h00000);
    rst = 1'b0;
    run = 1'b0;

    rst_s = 1'b0;
    run_s = 1'b1;
    edges(3);
    check("R3 slow before period", value_s, 20'h00000);
    edges(1);
    check("R3 slow first tick", value_s, 20'h00001);
    edges(4);
    check("R3 slow second tick", value_s, 20'h00002);
    edges(2);
    run_s = 1'b0;
    edges(10);
    check("R7 slow hold", value_s, 20'h00002);
    run_s = 1'b1;
    edges(1);
    check("R7 phase kept, mid", value_s, 20'h00002);
    edges(1);
    check("R7 phase kept, tick", value_s, 20'h00003);
    edges(2);
    rst_s = 1'b1;
    edges(1);
    check("R8 reset mid period", value_s, 20'h00000);
    rst_s = 1'b0;
    edges(3);
    check("R8 full period after reset", value_s, 20'h00000);
    edges(1);
    check("R8 first tick after reset", value_s, 20'h00001);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule